// File: doc/BRIEF.md
# Predicated Stateful Register Atom

This block holds an array of counters or state words in one block-RAM tile and updates them once per packet. Each request names a cell, an operation and up to two operands, plus a one-bit predicate. The block reads the cell, computes its new contents, writes them back, and returns the value the cell held before the update. One request can enter on every clock, and each result comes out flagged by `valid_out` a fixed number of cycles later, in the same order the requests entered.

Besides plain read and overwrite, the block can add to or subtract from a cell. It has two predicate-driven forms. In the conditional form, the addition takes place only when the predicate is set. In the two-way form, the predicate picks which of two addends is applied. Back-to-back updates to the same cell are chained through a forwarding path, so each request sees the result of the one before it. A separate control port lets software read or overwrite any cell. When a software write targets the cell that the packet path is writing on the same edge, the packet path wins and the software write is retried on the next edge.

Top module: `pred_state_atom`

## Requirements
- R1: Opcode 0 (read) returns the cell's current value and leaves the cell unchanged.
- R2: Opcode 1 (overwrite) returns the old value and stores operand A in the cell.
- R3: Opcode 2 (add) stores old + A and opcode 3 (subtract) stores old - A, both modulo 2^DATA_W. Both return the old value.
- R4: Opcode 4 (conditional add) stores old + A when the predicate is 1 and leaves the cell unchanged when it is 0. It returns the old value in both cases.
- R5: Opcode 5 (two-way add) stores old + A when the predicate is 1 and old + B when it is 0. It returns the old value.
- R6: Opcodes 6 and 7 behave as a read: the old value is returned and the cell is unchanged.
- R7: A request presented with `valid_in` high in cycle t produces `valid_out` high with its result in cycle t+3. Requests are accepted on consecutive cycles and their results leave in the order they arrived.
- R8: A request presented with `valid_in` low changes no cell and produces no `valid_out` pulse.
- R9: A request to a cell updated by the request one or two cycles earlier sees the updated value.
- R10: While `ctl_ready` is high, `ctl_we` stores `ctl_wdata` into cell `ctl_addr`, and later packet requests see that value. `ctl_re` in cycle t returns the stored cell value on `ctl_rdata`, with `ctl_rvalid` high in cycle t+1.
- R11: Suppose a control write in cycle t+1 targets the cell that a modifying request from cycle t is writing. Then the packet path's write happens first, `ctl_ready` is low in cycle t+2, the control write lands in its place, and `ctl_ready` is high again in cycle t+3. A control write to a different cell causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request qualifier |
| idx_in | input | IDX_W | Cell index |
| op_in | input | 3 | Operation code |
| pred_in | input | 1 | Predicate |
| opnd_a_in | input | DATA_W | Operand A (addend, subtrahend or write data) |
| opnd_b_in | input | DATA_W | Operand B (addend when the predicate is 0 in two-way mode) |
| valid_out | output | 1 | Result qualifier |
| result_out | output | DATA_W | Cell value before the update |
| ctl_we | input | 1 | Software write strobe |
| ctl_re | input | 1 | Software read strobe |
| ctl_addr | input | IDX_W | Software cell index |
| ctl_wdata | input | DATA_W | Software write data |
| ctl_ready | output | 1 | Software write can be accepted |
| ctl_rvalid | output | 1 | Software read data valid |
| ctl_rdata | output | DATA_W | Software read data |

## Verification
A packet result is due three cycles after its request. The bench therefore drives each request at a falling edge and compares `valid_out` and `result_out` at the third falling edge after that. In the table walk, vector i is checked while vector i+3 is driven. A software read is due one cycle after `ctl_re` and is sampled at the next falling edge. For the collision case, `ctl_ready` is sampled in the cycle after the colliding control write, where it must be low, and in the cycle after that, where it must be high again. The cell contents are then read back through both the packet path and the control port.

// File: rtl/psa_pkg.sv
package psa_pkg;
   localparam logic [2:0] OPC_READ   = 3'd0;
   localparam logic [2:0] OPC_WRITE  = 3'd1;
   localparam logic [2:0] OPC_ADD    = 3'd2;
   localparam logic [2:0] OPC_SUB    = 3'd3;
   localparam logic [2:0] OPC_PADD   = 3'd4;
   localparam logic [2:0] OPC_IFELSE = 3'd5;
   localparam int         MAX_CTL_W  = 32;
   localparam int         TILE_BITS  = 32768;
endpackage

// File: rtl/psa_alu.sv
module psa_alu #(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        op,
   input  logic              pred,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              wr,
   output logic [DATA_W-1:0] new_val
);
   import psa_pkg::*;

   always_comb begin
      wr      = 1'b0;
      new_val = old_val;
      unique case (op)
         OPC_WRITE: begin
            wr      = 1'b1;
            new_val = opnd_a;
         end
         OPC_ADD: begin
            wr      = 1'b1;
            new_val = old_val + opnd_a;
         end
         OPC_SUB: begin
            wr      = 1'b1;
            new_val = old_val - opnd_a;
         end
         OPC_PADD: begin
            wr      = pred;
            new_val = old_val + opnd_a;
         end
         OPC_IFELSE: begin
            wr      = 1'b1;
            new_val = old_val + (pred ? opnd_a : opnd_b);
         end
         default: begin
            wr      = 1'b0;
            new_val = old_val;
         end
      endcase
   end
endmodule

// File: rtl/psa_mem.sv
module psa_mem #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wa_en,
   input  logic [IDX_W-1:0]  wa_idx,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              cr_en,
   input  logic [IDX_W-1:0]  cr_idx,
   output logic [DATA_W-1:0] cr_data
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= cells[rd_idx];
      if (cr_en) cr_data <= cells[cr_idx];
      if (wa_en) cells[wa_idx] <= wa_data;
      if (wb_en) cells[wb_idx] <= wb_data;
   end

   // R11: the two write ports never target one cell on the same edge
   assert_one_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_en && wb_en) |-> (wa_idx != wb_idx))
      else $error("two writers on one cell");
endmodule

// File: rtl/psa_ctl_hold.sv
module psa_ctl_hold #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [IDX_W-1:0]  ctl_addr,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              dp_we,
   input  logic [IDX_W-1:0]  dp_idx,
   output logic              ready,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data
);
   logic              hold_v;
   logic [IDX_W-1:0]  hold_idx;
   logic [DATA_W-1:0] hold_data;
   logic              cand_v;
   logic              clash;

   assign ready   = !hold_v;
   assign cand_v  = hold_v || ctl_we;
   assign wb_idx  = hold_v ? hold_idx  : ctl_addr;
   assign wb_data = hold_v ? hold_data : ctl_wdata;
   assign clash   = cand_v && dp_we && (dp_idx == wb_idx);
   assign wb_en   = cand_v && !clash;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v    <= 1'b0;
         hold_idx  <= '0;
         hold_data <= '0;
      end else begin
         hold_v <= clash;
         if (clash) begin
            hold_idx  <= wb_idx;
            hold_data <= wb_data;
         end
      end
   end

   // R11: a held write drains as soon as the packet path leaves its cell alone
   assert_hold_drains_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !(dp_we && dp_idx == hold_idx)) |=> ready)
      else $error("held control write not retired");
   // R11: a write that meets a packet-path write to its cell stalls the port
   assert_clash_stalls_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && ctl_we && dp_we && dp_idx == ctl_addr) |=> !ready)
      else $error("clashing control write not held");
endmodule

// File: rtl/pred_state_atom.sv
module pred_state_atom #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [IDX_W-1:0]  idx_in,
   input  logic [2:0]        op_in,
   input  logic              pred_in,
   input  logic [DATA_W-1:0] opnd_a_in,
   input  logic [DATA_W-1:0] opnd_b_in,
   output logic              valid_out,
   output logic [DATA_W-1:0] result_out,
   input  logic              ctl_we,
   input  logic              ctl_re,
   input  logic [IDX_W-1:0]  ctl_addr,
   input  logic [DATA_W-1:0] ctl_wdata,
   output logic              ctl_ready,
   output logic              ctl_rvalid,
   output logic [DATA_W-1:0] ctl_rdata
);
   import psa_pkg::*;

   initial begin
      assert (DATA_W >= 1 && DATA_W <= MAX_CTL_W) else $error("DATA_W must fit the control port");
      assert (DEPTH >= 2) else $error("DEPTH too small");
      assert (DATA_W * DEPTH <= TILE_BITS) else $error("state exceeds one RAM tile");
   end

   // stage 1 request registers
   logic              s1_v, s1_pred;
   logic [IDX_W-1:0]  s1_idx;
   logic [2:0]        s1_op;
   logic [DATA_W-1:0] s1_a, s1_b;
   // forwarding of writes landing on the previous edge
   logic              fa_v, fb_v;
   logic [IDX_W-1:0]  fa_idx, fb_idx;
   logic [DATA_W-1:0] fa_data, fb_data;
   // stage 2
   logic              s2_v;
   logic [DATA_W-1:0] s2_res;

   logic [DATA_W-1:0] ram_q, old_val, new_val;
   logic              alu_wr, dp_we;
   logic              wb_en;
   logic [IDX_W-1:0]  wb_idx;
   logic [DATA_W-1:0] wb_data;

   always_comb begin
      if (fa_v && fa_idx == s1_idx)      old_val = fa_data;
      else if (fb_v && fb_idx == s1_idx) old_val = fb_data;
      else                               old_val = ram_q;
   end

   psa_alu #(.DATA_W(DATA_W)) u_alu (
      .op(s1_op), .pred(s1_pred), .old_val(old_val),
      .opnd_a(s1_a), .opnd_b(s1_b), .wr(alu_wr), .new_val(new_val)
   );

   assign dp_we = s1_v && alu_wr;

   psa_ctl_hold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
      .ctl_wdata(ctl_wdata), .dp_we(dp_we), .dp_idx(s1_idx),
      .ready(ctl_ready), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
   );

   psa_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .rd_en(valid_in), .rd_idx(idx_in), .rd_data(ram_q),
      .wa_en(dp_we), .wa_idx(s1_idx), .wa_data(new_val),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .cr_en(ctl_re), .cr_idx(ctl_addr), .cr_data(ctl_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v       <= 1'b0;
         s2_v       <= 1'b0;
         valid_out  <= 1'b0;
         fa_v       <= 1'b0;
         fb_v       <= 1'b0;
         ctl_rvalid <= 1'b0;
      end else begin
         s1_v       <= valid_in;
         s2_v       <= s1_v;
         valid_out  <= s2_v;
         fa_v       <= dp_we;
         fb_v       <= wb_en;
         ctl_rvalid <= ctl_re;
      end
   end

   always_ff @(posedge clk) begin
      if (valid_in) begin
         s1_idx  <= idx_in;
         s1_op   <= op_in;
         s1_pred <= pred_in;
         s1_a    <= opnd_a_in;
         s1_b    <= opnd_b_in;
      end
      fa_idx     <= s1_idx;
      fa_data    <= new_val;
      fb_idx     <= wb_idx;
      fb_data    <= wb_data;
      s2_res     <= old_val;
      result_out <= s2_res;
   end

   // R7: every valid request yields a result exactly three cycles later
   assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |-> ##3 valid_out)
      else $error("result missing three cycles after request");
   // R8: an idle cycle never yields a result
   assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |-> ##3 !valid_out)
      else $error("spurious valid_out");
   // R9: a request chained behind an update to its cell sees the new value
   assert_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_v && $past(dp_we) && s1_idx == $past(s1_idx)) |-> (old_val == $past(new_val)))
      else $error("stale value used after same-cell update");
   // R4: a conditional add with a false predicate never writes
   assert_pred_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_v && s1_op == OPC_PADD && !s1_pred) |-> !dp_we)
      else $error("conditional add wrote with predicate low");
   // R10: software read data follows its strobe by one cycle
   assert_ctl_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_re |=> ctl_rvalid)
      else $error("ctl_rvalid missing");
endmodule

// File: tb/pred_state_atom_test.sv
`timescale 1ns/1ps
module pred_state_atom_test;
   localparam int DW = 32;
   localparam int IW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_in = 1'b0;
   logic [IW-1:0] idx_in = '0;
   logic [2:0]    op_in = '0;
   logic          pred_in = 1'b0;
   logic [DW-1:0] opnd_a_in = '0, opnd_b_in = '0;
   logic          valid_out;
   logic [DW-1:0] result_out;
   logic          ctl_we = 1'b0, ctl_re = 1'b0;
   logic [IW-1:0] ctl_addr = '0;
   logic [DW-1:0] ctl_wdata = '0;
   logic          ctl_ready, ctl_rvalid;
   logic [DW-1:0] ctl_rdata;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   pred_state_atom #(.DATA_W(DW), .DEPTH(256)) uut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .idx_in(idx_in),
      .op_in(op_in), .pred_in(pred_in), .opnd_a_in(opnd_a_in),
      .opnd_b_in(opnd_b_in), .valid_out(valid_out), .result_out(result_out),
      .ctl_we(ctl_we), .ctl_re(ctl_re), .ctl_addr(ctl_addr),
      .ctl_wdata(ctl_wdata), .ctl_ready(ctl_ready), .ctl_rvalid(ctl_rvalid),
      .ctl_rdata(ctl_rdata)
   );

   typedef struct packed {
      logic [2:0]    op;
      logic [IW-1:0] idx;
      logic          pred;
      logic [DW-1:0] a;
      logic [DW-1:0] b;
      logic [DW-1:0] exp;
      logic [7:0]    rq;
   } vec_t;

   localparam int NV = 16;
   // cells before the walk: 1=100, 2=50, 3=7, 4=0
   localparam vec_t VECS [NV] = '{
      '{3'd0, 8'd1, 1'b0, 32'd0,          32'd0,   32'd100,        8'd1},  // R1
      '{3'd2, 8'd1, 1'b0, 32'd5,          32'd0,   32'd100,        8'd3},  // R3 -> 105
      '{3'd2, 8'd1, 1'b0, 32'd3,          32'd0,   32'd105,        8'd9},  // R9 gap 1 -> 108
      '{3'd3, 8'd2, 1'b0, 32'd60,         32'd0,   32'd50,         8'd3},  // R3 wrap -> FFFFFFF6
      '{3'd0, 8'd1, 1'b0, 32'd0,          32'd0,   32'd108,        8'd9},  // R9 gap 2
      '{3'd4, 8'd3, 1'b0, 32'd9,          32'd0,   32'd7,          8'd4},  // R4 pred 0
      '{3'd4, 8'd3, 1'b1, 32'd9,          32'd0,   32'd7,          8'd4},  // R4 pred 1 -> 16
      '{3'd5, 8'd3, 1'b1, 32'd4,          32'd100, 32'd16,         8'd5},  // R5 pred 1 -> 20
      '{3'd5, 8'd3, 1'b0, 32'd4,          32'd100, 32'd20,         8'd5},  // R5 pred 0 -> 120
      '{3'd1, 8'd2, 1'b0, 32'hDEADBEEF,   32'd0,   32'hFFFFFFF6,   8'd2},  // R2
      '{3'd6, 8'd2, 1'b1, 32'd1,          32'd1,   32'hDEADBEEF,   8'd6},  // R6
      '{3'd7, 8'd2, 1'b1, 32'd1,          32'd1,   32'hDEADBEEF,   8'd6},  // R6
      '{3'd0, 8'd3, 1'b0, 32'd0,          32'd0,   32'd120,        8'd5},  // R5 final
      '{3'd0, 8'd2, 1'b0, 32'd0,          32'd0,   32'hDEADBEEF,   8'd6},  // R6 unchanged
      '{3'd1, 8'd4, 1'b0, 32'd77,         32'd0,   32'd0,          8'd2},  // R2
      '{3'd0, 8'd4, 1'b0, 32'd0,          32'd0,   32'd77,         8'd9}   // R9 after write
   };

   task automatic check(input bit ok, input string rq, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic idle_dp();
      valid_in = 1'b0;
      op_in = '0; idx_in = '0; pred_in = 1'b0; opnd_a_in = '0; opnd_b_in = '0;
   endtask

   task automatic drive_dp(input logic [2:0] op, input logic [IW-1:0] idx,
                           input logic pred, input logic [DW-1:0] a, input logic [DW-1:0] b);
      valid_in = 1'b1; op_in = op; idx_in = idx; pred_in = pred;
      opnd_a_in = a; opnd_b_in = b;
   endtask

   // one request alone, result sampled at the third falling edge
   task automatic run_one(input logic [2:0] op, input logic [IW-1:0] idx, input logic pred,
                          input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [DW-1:0] exp, input string rq);
      @(negedge clk); drive_dp(op, idx, pred, a, b);
      @(negedge clk); idle_dp();
      @(negedge clk);
      @(negedge clk);
      check(valid_out === 1'b1, {rq, " valid"}, {31'd0, valid_out}, 1);
      check(result_out === exp, rq, result_out, exp);
   endtask

   task automatic ctl_write(input logic [IW-1:0] addr, input logic [DW-1:0] data);
      @(negedge clk);
      ctl_we = 1'b1; ctl_addr = addr; ctl_wdata = data;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(valid_out === 1'b0, "R7 reset valid_out", {31'd0, valid_out}, 0);
      check(ctl_ready === 1'b1, "R10 reset ctl_ready", {31'd0, ctl_ready}, 1);
      check(ctl_rvalid === 1'b0, "R10 reset ctl_rvalid", {31'd0, ctl_rvalid}, 0);

      // R10: software initialisation
      ctl_write(8'd1, 32'd100);
      ctl_write(8'd2, 32'd50);
      ctl_write(8'd3, 32'd7);
      ctl_write(8'd4, 32'd0);
      ctl_write(8'd5, 32'd10);
      repeat (2) @(negedge clk);

      // table walk, one request per cycle (R7)
      for (int i = 0; i < NV + 3; i++) begin
         if (i < 3)
            check(valid_out === 1'b0, "R7 pipeline fill", {31'd0, valid_out}, 0);
         else begin
            check(valid_out === 1'b1, "R7 back-to-back valid", {31'd0, valid_out}, 1);
            check(result_out === VECS[i-3].exp, $sformatf("R%0d vector %0d", VECS[i-3].rq, i-3),
                  result_out, VECS[i-3].exp);
         end
         if (i < NV) drive_dp(VECS[i].op, VECS[i].idx, VECS[i].pred, VECS[i].a, VECS[i].b);
         else idle_dp();
         @(negedge clk);
      end
      check(valid_out === 1'b0, "R7 drain", {31'd0, valid_out}, 0);

      // R8: request with valid_in low is ignored
      op_in = 3'd1; idx_in = 8'd1; opnd_a_in = 32'd999; valid_in = 1'b0;
      @(negedge clk); idle_dp();
      for (int k = 0; k < 4; k++) begin
         check(valid_out === 1'b0, "R8 no result", {31'd0, valid_out}, 0);
         @(negedge clk);
      end
      run_one(3'd0, 8'd1, 1'b0, 0, 0, 32'd108, "R8 cell kept");

      // R10: software read
      @(negedge clk); ctl_re = 1'b1; ctl_addr = 8'd3;
      @(negedge clk); ctl_re = 1'b0;
      check(ctl_rvalid === 1'b1, "R10 rvalid", {31'd0, ctl_rvalid}, 1);
      check(ctl_rdata === 32'd120, "R10 rdata", ctl_rdata, 120);

      // R11: control write to a different cell does not stall
      @(negedge clk); drive_dp(3'd2, 8'd4, 1'b0, 32'd1, 0);
      @(negedge clk); idle_dp(); ctl_we = 1'b1; ctl_addr = 8'd6; ctl_wdata = 32'd33;
      @(negedge clk); ctl_we = 1'b0;
      check(ctl_ready === 1'b1, "R11 no stall other cell", {31'd0, ctl_ready}, 1);
      repeat (2) @(negedge clk);

      // R11: collision with packet-path update of the same cell
      @(negedge clk); drive_dp(3'd2, 8'd5, 1'b0, 32'd1, 0);
      @(negedge clk); idle_dp(); ctl_we = 1'b1; ctl_addr = 8'd5; ctl_wdata = 32'd500;
      @(negedge clk); ctl_we = 1'b0;
      check(ctl_ready === 1'b0, "R11 stall", {31'd0, ctl_ready}, 0);
      @(negedge clk);
      check(ctl_ready === 1'b1, "R11 released", {31'd0, ctl_ready}, 1);
      check(valid_out === 1'b1 && result_out === 32'd10, "R11 add result", result_out, 10);
      run_one(3'd0, 8'd5, 1'b0, 0, 0, 32'd500, "R11 control value wins");
      run_one(3'd0, 8'd6, 1'b0, 0, 0, 32'd33, "R10 other cell written");
      run_one(3'd0, 8'd4, 1'b0, 0, 0, 32'd78, "R3 add before control write");
      @(negedge clk); ctl_re = 1'b1; ctl_addr = 8'd5;
      @(negedge clk); ctl_re = 1'b0;
      check(ctl_rdata === 32'd500, "R11 readback", ctl_rdata, 500);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule